// File: doc/BRIEF.md
# Fail-Safe Mode Supervisor

This block is the supervisory state machine for a multichannel output driver. It runs in a normal mode, where software sets the channel enables and per-channel fault policy through write strobes. It drops into one of two fail-safe sub-modes when software forces it there or when the host watchdog expires. An external select pin picks the sub-mode, and the block follows that pin while in fail-safe. Each sub-mode has its own stored channel-enable pattern, which is loaded on arrival.

Entering fail-safe puts the policy register back to its default value and sets a configuration lock. The lock freezes the writable registers. To return to normal, software must clear the lock and clear all fault flags, and then write the release bit. The block also combines the fault flags. On a fault, a channel marked "others-on" turns off only itself. A channel marked "all-fail" turns off every channel and raises the error output. When every channel is marked all-fail and a fault occurs, the block goes into a low-power fault mode that turns off the serial-interface enable.

Top module: `fs_supervisor`

## Requirements
- R1: After reset, mode_out is 2'b00 (normal), ch_en_out equals the EN_DEFAULT parameter, lock_out is 0, err_out is 0 and serial_en is 1.
- R2: A write to the channel-enable or policy register takes effect on the next clock edge when lock_out is 0, and is ignored when lock_out is 1.
- R3: In normal mode, a force write with data 1, or a watchdog-timeout pulse, moves the block into fail-safe. The sub-mode is taken from the synchronized pin: mode 2'b01 for pin low, 2'b10 for pin high.
- R4: On entry to fail-safe, lock_out becomes 1, the policy register returns to POLICY_DEFAULT, and the channel-enable register loads stored_pat0 (sub-mode 2'b01) or stored_pat1 (sub-mode 2'b10).
- R5: pin_flag equals the select pin level two clock edges earlier. While in fail-safe, the sub-mode follows pin_flag one edge later, and the matching stored pattern is reloaded on each switch.
- R6: A switch between the two fail-safe sub-modes leaves fault_flags unchanged.
- R7: A release write with data 1 returns fail-safe to normal only if lock_out is 0 and fault_flags is all zero. Otherwise the write is ignored. After an accepted release, release_bit is 1 for exactly one cycle.
- R8: A pulse on fault_in[i] sets fault_flags[i], which stays set until a flag-clear strobe. A flagged channel whose policy bit is 0 (others-on) is turned off alone.
- R9: A set flag on a channel whose policy bit is 1 (all-fail) forces every ch_en_out bit to 0 and raises err_out.
- R10: If all policy bits are 1 and any flag is set, the block enters low-power mode 2'b11. In that mode serial_en is 0, ch_en_out is 0 and err_out is 1, and the block stays there until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fs_sel_pin | input | 1 | Asynchronous fail-safe sub-mode select pin |
| wdt_timeout | input | 1 | Host watchdog expiry pulse |
| wr_en_strb | input | 1 | Channel-enable register write strobe |
| wr_en_data | input | NUM_CH | Channel-enable write data |
| wr_pol_strb | input | 1 | Fault-policy register write strobe |
| wr_pol_data | input | NUM_CH | Policy write data, 1 = all-fail |
| wr_lock_strb | input | 1 | Lock bit write strobe |
| wr_lock_data | input | 1 | Lock bit write data |
| wr_force_strb | input | 1 | Force bit write strobe |
| wr_force_data | input | 1 | Force bit write data |
| wr_release_strb | input | 1 | Release bit write strobe |
| wr_release_data | input | 1 | Release bit write data |
| wr_flagclr_strb | input | 1 | Clears all fault flags |
| fault_in | input | NUM_CH | Per-channel fault pulses |
| stored_pat0 | input | NUM_CH | Stored enable pattern for sub-mode 0 |
| stored_pat1 | input | NUM_CH | Stored enable pattern for sub-mode 1 |
| ch_en_out | output | NUM_CH | Effective channel enables |
| mode_out | output | 2 | 00 normal, 01 sub-mode 0, 10 sub-mode 1, 11 low power |
| lock_out | output | 1 | Configuration lock |
| pin_flag | output | 1 | Synchronized select pin level |
| fault_flags | output | NUM_CH | Sticky fault flags |
| err_out | output | 1 | Error indicator |
| serial_en | output | 1 | Serial-interface enable |
| release_bit | output | 1 | Self-clearing release bit |

## Verification
The bench builds the block with NUM_CH = 4, SYNC_STAGES = 2, EN_DEFAULT = 4'b1111 and POLICY_DEFAULT = 4'b0000. The two stored patterns are the disjoint values 4'b0011 and 4'b1100, so every sub-mode switch changes every enable bit. Because the default policy is all others-on, a fault injected after entry shows whether the policy reset took place: a policy that survived entry would blank every channel. With four channels, a mixed policy (all-fail on one channel only) and the full all-fail set that triggers low-power mode can both be written.

// File: rtl/fs_pkg.sv
package fs_pkg;
   typedef enum logic [1:0] {
      FS_NORMAL = 2'b00,
      FS_SUB0   = 2'b01,
      FS_SUB1   = 2'b10,
      FS_LOWPWR = 2'b11
   } fs_mode_e;
endpackage

// File: rtl/fs_sync.sv
module fs_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_in,
   output logic q_out
);
   if (STAGES < 2) begin : g_bad_stages
      $error("fs_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d_in};
   end

   assign q_out = chain_q[STAGES-1];
endmodule

// File: rtl/fs_cfg.sv
module fs_cfg #(
   parameter int              NUM_CH         = 4,
   parameter logic [NUM_CH-1:0] EN_DEFAULT     = '1,
   parameter logic [NUM_CH-1:0] POLICY_DEFAULT = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enter_fs,
   input  logic              load_pat,
   input  logic [NUM_CH-1:0] pat,
   input  logic              wr_en_strb,
   input  logic [NUM_CH-1:0] wr_en_data,
   input  logic              wr_pol_strb,
   input  logic [NUM_CH-1:0] wr_pol_data,
   input  logic              wr_lock_strb,
   input  logic              wr_lock_data,
   output logic [NUM_CH-1:0] en_q,
   output logic [NUM_CH-1:0] pol_q,
   output logic              lock_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= EN_DEFAULT;
         pol_q  <= POLICY_DEFAULT;
         lock_q <= 1'b0;
      end else begin
         if (enter_fs)          lock_q <= 1'b1;
         else if (wr_lock_strb) lock_q <= wr_lock_data;

         if (enter_fs)                   pol_q <= POLICY_DEFAULT;
         else if (wr_pol_strb && !lock_q) pol_q <= wr_pol_data;

         if (load_pat)                   en_q <= pat;
         else if (wr_en_strb && !lock_q) en_q <= wr_en_data;
      end
   end
endmodule

// File: rtl/fs_fault.sv
module fs_fault #(
   parameter int NUM_CH = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] fault_in,
   input  logic              clr,
   input  logic [NUM_CH-1:0] pol,
   output logic [NUM_CH-1:0] flags_q,
   output logic              kill_all,
   output logic              lowpwr_req
);
   for (genvar i = 0; i < NUM_CH; i++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) flags_q[i] <= 1'b0;
         else        flags_q[i] <= fault_in[i] | (flags_q[i] & ~clr);
      end
   end

   assign kill_all   = |(flags_q & pol);
   assign lowpwr_req = (&pol) & (|flags_q);
endmodule

// File: rtl/fs_supervisor.sv
module fs_supervisor
   import fs_pkg::*;
#(
   parameter int                NUM_CH         = 4,
   parameter int                SYNC_STAGES    = 2,
   parameter logic [NUM_CH-1:0] EN_DEFAULT     = '1,
   parameter logic [NUM_CH-1:0] POLICY_DEFAULT = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fs_sel_pin,
   input  logic              wdt_timeout,
   input  logic              wr_en_strb,
   input  logic [NUM_CH-1:0] wr_en_data,
   input  logic              wr_pol_strb,
   input  logic [NUM_CH-1:0] wr_pol_data,
   input  logic              wr_lock_strb,
   input  logic              wr_lock_data,
   input  logic              wr_force_strb,
   input  logic              wr_force_data,
   input  logic              wr_release_strb,
   input  logic              wr_release_data,
   input  logic              wr_flagclr_strb,
   input  logic [NUM_CH-1:0] fault_in,
   input  logic [NUM_CH-1:0] stored_pat0,
   input  logic [NUM_CH-1:0] stored_pat1,
   output logic [NUM_CH-1:0] ch_en_out,
   output logic [1:0]        mode_out,
   output logic              lock_out,
   output logic              pin_flag,
   output logic [NUM_CH-1:0] fault_flags,
   output logic              err_out,
   output logic              serial_en,
   output logic              release_bit
);
   if (NUM_CH < 1) begin : g_bad_ch
      $error("fs_supervisor: NUM_CH must be at least 1");
   end

   fs_mode_e          state_q, state_d;
   logic              sel_s;
   logic              in_fs, enter_fs, load_pat, rel_ok;
   logic [NUM_CH-1:0] pat, en_q, pol_q, flags_q;
   logic              lock_q, kill_all, lowpwr_req, release_q;

   fs_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  (fs_sel_pin),
      .q_out (sel_s)
   );

   fs_fault #(.NUM_CH(NUM_CH)) u_fault (
      .clk        (clk),
      .rst_n      (rst_n),
      .fault_in   (fault_in),
      .clr        (wr_flagclr_strb),
      .pol        (pol_q),
      .flags_q    (flags_q),
      .kill_all   (kill_all),
      .lowpwr_req (lowpwr_req)
   );

   assign in_fs    = (state_q == FS_SUB0) || (state_q == FS_SUB1);
   assign enter_fs = (state_q == FS_NORMAL) && !lowpwr_req &&
                     ((wr_force_strb && wr_force_data) || wdt_timeout);
   assign rel_ok   = in_fs && !lowpwr_req && wr_release_strb && wr_release_data &&
                     !lock_q && (flags_q == '0);

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         FS_NORMAL: begin
            if (lowpwr_req)    state_d = FS_LOWPWR;
            else if (enter_fs) state_d = sel_s ? FS_SUB1 : FS_SUB0;
         end
         FS_SUB0, FS_SUB1: begin
            if (lowpwr_req)  state_d = FS_LOWPWR;
            else if (rel_ok) state_d = FS_NORMAL;
            else             state_d = sel_s ? FS_SUB1 : FS_SUB0;
         end
         default: state_d = FS_LOWPWR;
      endcase
   end

   assign load_pat = ((state_d == FS_SUB0) || (state_d == FS_SUB1)) && (state_d != state_q);
   assign pat      = (state_d == FS_SUB1) ? stored_pat1 : stored_pat0;

   fs_cfg #(
      .NUM_CH         (NUM_CH),
      .EN_DEFAULT     (EN_DEFAULT),
      .POLICY_DEFAULT (POLICY_DEFAULT)
   ) u_cfg (
      .clk          (clk),
      .rst_n        (rst_n),
      .enter_fs     (enter_fs),
      .load_pat     (load_pat),
      .pat          (pat),
      .wr_en_strb   (wr_en_strb),
      .wr_en_data   (wr_en_data),
      .wr_pol_strb  (wr_pol_strb),
      .wr_pol_data  (wr_pol_data),
      .wr_lock_strb (wr_lock_strb),
      .wr_lock_data (wr_lock_data),
      .en_q         (en_q),
      .pol_q        (pol_q),
      .lock_q       (lock_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= FS_NORMAL;
         release_q <= 1'b0;
      end else begin
         state_q   <= state_d;
         release_q <= rel_ok;
      end
   end

   assign ch_en_out   = (state_q == FS_LOWPWR || kill_all) ? '0 : (en_q & ~flags_q);
   assign mode_out    = state_q;
   assign lock_out    = lock_q;
   assign pin_flag    = sel_s;
   assign fault_flags = flags_q;
   assign err_out     = kill_all || (state_q == FS_LOWPWR);
   assign serial_en   = (state_q != FS_LOWPWR);
   assign release_bit = release_q;
endmodule

// File: rtl/fs_supervisor_chk.sv
module fs_supervisor_chk #(
   parameter int NUM_CH = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_flagclr_strb,
   input logic [NUM_CH-1:0] ch_en_out,
   input logic [1:0]        mode_out,
   input logic              lock_out,
   input logic              pin_flag,
   input logic [NUM_CH-1:0] fault_flags,
   input logic              serial_en,
   input logic              release_bit
);
   AST_LOCK_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(mode_out) == 2'b00 && (mode_out == 2'b01 || mode_out == 2'b10)) |-> lock_out); // R4

   AST_SUBMODE_TRACKS_PIN: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(mode_out) == 2'b01 || $past(mode_out) == 2'b10) &&
       (mode_out == 2'b01 || mode_out == 2'b10))
      |-> (mode_out == ($past(pin_flag) ? 2'b10 : 2'b01))); // R5

   AST_FLAGS_KEPT_ON_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
      ((($past(mode_out) == 2'b01 && mode_out == 2'b10) ||
        ($past(mode_out) == 2'b10 && mode_out == 2'b01)) && !$past(wr_flagclr_strb))
      |-> ((fault_flags & $past(fault_flags)) == $past(fault_flags))); // R6

   AST_EXIT_GUARDED: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(mode_out) == 2'b01 || $past(mode_out) == 2'b10) && mode_out == 2'b00)
      |-> (!$past(lock_out) && $past(fault_flags) == '0)); // R7

   AST_RELEASE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      release_bit |=> !release_bit); // R7

   AST_LOWPWR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_out == 2'b11) |-> (!serial_en && ch_en_out == '0)); // R10

   AST_LOWPWR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(mode_out) == 2'b11) |-> (mode_out == 2'b11)); // R10
endmodule

bind fs_supervisor fs_supervisor_chk #(.NUM_CH(NUM_CH)) u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .wr_flagclr_strb (wr_flagclr_strb),
   .ch_en_out       (ch_en_out),
   .mode_out        (mode_out),
   .lock_out        (lock_out),
   .pin_flag        (pin_flag),
   .fault_flags     (fault_flags),
   .serial_en       (serial_en),
   .release_bit     (release_bit)
);

// File: tb/tb_fs_supervisor.sv
`timescale 1ns/1ps
module tb_fs_supervisor;
   localparam int N = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic fs_sel_pin = 1'b0, wdt_timeout = 1'b0;
   logic wr_en_strb = 1'b0, wr_pol_strb = 1'b0, wr_lock_strb = 1'b0, wr_lock_data = 1'b0;
   logic wr_force_strb = 1'b0, wr_force_data = 1'b0, wr_release_strb = 1'b0, wr_release_data = 1'b0;
   logic wr_flagclr_strb = 1'b0;
   logic [N-1:0] wr_en_data = '0, wr_pol_data = '0, fault_in = '0;
   logic [N-1:0] stored_pat0 = 4'b0011, stored_pat1 = 4'b1100;
   logic [N-1:0] ch_en_out, fault_flags;
   logic [1:0]   mode_out;
   logic lock_out, pin_flag, err_out, serial_en, release_bit;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   fs_supervisor #(.NUM_CH(N), .SYNC_STAGES(2), .EN_DEFAULT(4'b1111), .POLICY_DEFAULT(4'b0000)) dut (
      .clk(clk), .rst_n(rst_n), .fs_sel_pin(fs_sel_pin), .wdt_timeout(wdt_timeout),
      .wr_en_strb(wr_en_strb), .wr_en_data(wr_en_data),
      .wr_pol_strb(wr_pol_strb), .wr_pol_data(wr_pol_data),
      .wr_lock_strb(wr_lock_strb), .wr_lock_data(wr_lock_data),
      .wr_force_strb(wr_force_strb), .wr_force_data(wr_force_data),
      .wr_release_strb(wr_release_strb), .wr_release_data(wr_release_data),
      .wr_flagclr_strb(wr_flagclr_strb), .fault_in(fault_in),
      .stored_pat0(stored_pat0), .stored_pat1(stored_pat1),
      .ch_en_out(ch_en_out), .mode_out(mode_out), .lock_out(lock_out),
      .pin_flag(pin_flag), .fault_flags(fault_flags), .err_out(err_out),
      .serial_en(serial_en), .release_bit(release_bit)
   );

   localparam logic [3:0] OP_WREN = 4'd1, OP_WRPOL = 4'd2, OP_FORCE = 4'd3, OP_WDT = 4'd4,
                          OP_PIN = 4'd5, OP_LOCK = 4'd6, OP_REL = 4'd7, OP_FAULT = 4'd8,
                          OP_FCLR = 4'd9;

   typedef struct packed {
      logic [3:0] op;
      logic [3:0] data;
      logic [1:0] mode;
      logic [3:0] chen;
      logic       lock;
      logic [3:0] flags;
      logic       err;
      logic [3:0] req;
   } vec_t;

   localparam int NV = 23;
   localparam vec_t VECS [NV] = '{
      '{OP_WREN,  4'b1010, 2'b00, 4'b1010, 1'b0, 4'b0000, 1'b0, 4'd2},  // R2 write unlocked
      '{OP_WRPOL, 4'b0100, 2'b00, 4'b1010, 1'b0, 4'b0000, 1'b0, 4'd2},  // R2
      '{OP_FORCE, 4'b0001, 2'b01, 4'b0011, 1'b1, 4'b0000, 1'b0, 4'd4},  // R3 R4 entry pin low
      '{OP_PIN,   4'b0001, 2'b10, 4'b1100, 1'b1, 4'b0000, 1'b0, 4'd5},  // R5 switch to sub 1
      '{OP_WREN,  4'b1111, 2'b10, 4'b1100, 1'b1, 4'b0000, 1'b0, 4'd2},  // R2 locked write ignored
      '{OP_REL,   4'b0001, 2'b10, 4'b1100, 1'b1, 4'b0000, 1'b0, 4'd7},  // R7 release while locked
      '{OP_FAULT, 4'b0100, 2'b10, 4'b1000, 1'b1, 4'b0100, 1'b0, 4'd8},  // R8 others-on
      '{OP_PIN,   4'b0000, 2'b01, 4'b0011, 1'b1, 4'b0100, 1'b0, 4'd6},  // R6 flags kept
      '{OP_LOCK,  4'b0000, 2'b01, 4'b0011, 1'b0, 4'b0100, 1'b0, 4'd7},  // R7 unlock
      '{OP_REL,   4'b0001, 2'b01, 4'b0011, 1'b0, 4'b0100, 1'b0, 4'd7},  // R7 release with flag set
      '{OP_FCLR,  4'b0000, 2'b01, 4'b0011, 1'b0, 4'b0000, 1'b0, 4'd8},  // R8 flag clear
      '{OP_REL,   4'b0001, 2'b00, 4'b0011, 1'b0, 4'b0000, 1'b0, 4'd7},  // R7 accepted
      '{OP_WDT,   4'b0000, 2'b01, 4'b0011, 1'b1, 4'b0000, 1'b0, 4'd3},  // R3 watchdog entry
      '{OP_LOCK,  4'b0000, 2'b01, 4'b0011, 1'b0, 4'b0000, 1'b0, 4'd7},  // R7
      '{OP_REL,   4'b0001, 2'b00, 4'b0011, 1'b0, 4'b0000, 1'b0, 4'd7},  // R7
      '{OP_WRPOL, 4'b0100, 2'b00, 4'b0011, 1'b0, 4'b0000, 1'b0, 4'd2},  // R2
      '{OP_WREN,  4'b1111, 2'b00, 4'b1111, 1'b0, 4'b0000, 1'b0, 4'd2},  // R2
      '{OP_FAULT, 4'b0100, 2'b00, 4'b0000, 1'b0, 4'b0100, 1'b1, 4'd9},  // R9 all-fail kill
      '{OP_FCLR,  4'b0000, 2'b00, 4'b1111, 1'b0, 4'b0000, 1'b0, 4'd9},  // R9 recovery
      '{OP_FORCE, 4'b0001, 2'b01, 4'b0011, 1'b1, 4'b0000, 1'b0, 4'd4},  // R4
      '{OP_FAULT, 4'b0100, 2'b01, 4'b0011, 1'b1, 4'b0100, 1'b0, 4'd4},  // R4 policy reset to default
      '{OP_FCLR,  4'b0000, 2'b01, 4'b0011, 1'b1, 4'b0000, 1'b0, 4'd8},  // R8
      '{OP_WREN,  4'b0000, 2'b01, 4'b0011, 1'b1, 4'b0000, 1'b0, 4'd2}   // R2 locked in fail-safe
   };

   task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
      end
   endtask

   task automatic apply(input logic [3:0] op, input logic [3:0] d);
      @(negedge clk);
      case (op)
         OP_WREN:  begin wr_en_strb = 1'b1; wr_en_data = d; end
         OP_WRPOL: begin wr_pol_strb = 1'b1; wr_pol_data = d; end
         OP_FORCE: begin wr_force_strb = 1'b1; wr_force_data = d[0]; end
         OP_WDT:   wdt_timeout = 1'b1;
         OP_PIN:   fs_sel_pin = d[0];
         OP_LOCK:  begin wr_lock_strb = 1'b1; wr_lock_data = d[0]; end
         OP_REL:   begin wr_release_strb = 1'b1; wr_release_data = d[0]; end
         OP_FAULT: fault_in = d;
         OP_FCLR:  wr_flagclr_strb = 1'b1;
         default: ;
      endcase
      @(negedge clk);
      wr_en_strb = 1'b0; wr_pol_strb = 1'b0; wr_force_strb = 1'b0; wdt_timeout = 1'b0;
      wr_lock_strb = 1'b0; wr_release_strb = 1'b0; wr_flagclr_strb = 1'b0; fault_in = '0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 values during and after reset
      check("R1", "mode in reset", {6'd0, mode_out}, 8'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", "mode", {6'd0, mode_out}, 8'd0);
      check("R1", "ch_en", {4'd0, ch_en_out}, 8'b1111);
      check("R1", "lock/err/serial", {5'd0, lock_out, err_out, serial_en}, 8'b001);

      for (int i = 0; i < NV; i++) begin
         string tag;
         apply(VECS[i].op, VECS[i].data);
         repeat (3) @(negedge clk);
         tag = $sformatf("R%0d row%0d", VECS[i].req, i);
         check(tag, "mode",  {6'd0, mode_out},    {6'd0, VECS[i].mode});
         check(tag, "ch_en", {4'd0, ch_en_out},   {4'd0, VECS[i].chen});
         check(tag, "lock",  {7'd0, lock_out},    {7'd0, VECS[i].lock});
         check(tag, "flags", {4'd0, fault_flags}, {4'd0, VECS[i].flags});
         check(tag, "err",   {7'd0, err_out},     {7'd0, VECS[i].err});
         check(tag, "serial_en", {7'd0, serial_en}, 8'd1);
      end

      // R7 release bit lasts one cycle
      apply(OP_LOCK, 4'b0000);
      @(negedge clk);
      wr_release_strb = 1'b1; wr_release_data = 1'b1;
      @(negedge clk);
      wr_release_strb = 1'b0;
      check("R7", "release_bit set", {7'd0, release_bit}, 8'd1);
      check("R7", "mode after release", {6'd0, mode_out}, 8'd0);
      @(negedge clk);
      check("R7", "release_bit cleared", {7'd0, release_bit}, 8'd0);

      // R5 two-edge pin synchronizer latency
      fs_sel_pin = 1'b1;
      @(negedge clk);
      check("R5", "pin_flag after 1 edge", {7'd0, pin_flag}, 8'd0);
      @(negedge clk);
      check("R5", "pin_flag after 2 edges", {7'd0, pin_flag}, 8'd1);
      fs_sel_pin = 1'b0;
      repeat (3) @(negedge clk);

      // R10 low-power fault mode
      apply(OP_WRPOL, 4'b1111);
      apply(OP_FAULT, 4'b0001);
      repeat (3) @(negedge clk);
      check("R10", "mode", {6'd0, mode_out}, 8'b11);
      check("R10", "serial_en", {7'd0, serial_en}, 8'd0);
      check("R10", "ch_en", {4'd0, ch_en_out}, 8'd0);
      check("R10", "err", {7'd0, err_out}, 8'd1);
      apply(OP_FCLR, 4'b0000);
      apply(OP_FORCE, 4'b0001);
      repeat (3) @(negedge clk);
      check("R10", "mode held", {6'd0, mode_out}, 8'b11);

      // R1 reset leaves low power
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", "mode after reset", {6'd0, mode_out}, 8'd0);
      check("R1", "ch_en after reset", {4'd0, ch_en_out}, 8'b1111);
      check("R1", "serial after reset", {7'd0, serial_en}, 8'd1);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule